// File: doc/BRIEF.md
# Configurable Byte SPI Master

This block is a byte-wide SPI master placed on a simple single-cycle register bus. A 16-bit configuration word sets the serial clock rate, the wire-level polarities, the bit order, the edge on which the master samples its input, whether chip select stays asserted between bytes, whether the master is enabled, whether it raises an interrupt, and which of two pin sets the serial signals use. A write to the data address launches one full-duplex byte. The received byte is then read back from the same address, with a busy flag in the top bit.

The serial signals go either to the external pin set or to an internal slave port. The pin set that is not selected rests at its idle levels. Any bus write that arrives during a byte is stalled with a wait signal and is accepted on the first idle cycle. A config write therefore never changes the settings in the middle of a byte.

Top module: `spim_top`

## Requirements
- R1: After reset the configuration reads 0x0002 (prescaler 2, all option bits 0). No transfer is running, the interrupt is low, and both pin sets show SCK low and chip select high.
- R2: With bus_addr=1, a write while enabled and idle starts one transfer of 8 bits. The transfer produces exactly 16 SCK edges. Busy (bus_rdata bit 15 at bus_addr=1) reads 1 from the cycle after acceptance for 18 half-periods, then reads 0.
- R3: One SCK half-period lasts max(P,1)+1 clocks, where P is configuration bits 7:0. A value of 0 therefore behaves like 1.
- R4: Configuration bit 8 sets the bit order for both directions: 0 shifts MSB first, 1 shifts LSB first.
- R5: Configuration bit 9 sets the active level of chip select: 0 means active low, 1 means active high.
- R6: Configuration bit 10 inverts SCK. With the bit at 0 the idle level is low; with it at 1 the idle level is high.
- R7: Configuration bit 11 sets the sampling edge. With 0, MOSI changes on trailing edges and MISO is sampled on leading edges. With 1, MOSI changes and MISO is sampled on the trailing edges. In both modes the first MOSI bit is present before the first edge.
- R8: When configuration bit 12 (stream) is set, chip select stays active after a byte ends. A config write with bit 12 or bit 13 clear releases it.
- R9: When stream is clear, chip select becomes active before the first SCK edge of a byte and goes inactive when that byte completes. It stays active for the whole byte.
- R10: When configuration bit 13 (enable) is 0, a data write is ignored. No busy, no SCK activity and no chip select result, and the received byte keeps its value.
- R11: When configuration bit 14 is set, irq pulses high for exactly one clock in the cycle in which busy first reads 0 after a byte. When the bit is clear, irq stays low.
- R12: When configuration bit 15 is 0, the serial signals use the ext_* pins. When it is 1, they use the int_* pins, and MISO is taken from the selected set. The unselected set holds SCK at its idle level and chip select inactive.
- R13: A write to either address while busy holds bus_wait high and is not accepted until the byte ends. The held write then takes effect.
- R14: A read at bus_addr=1 returns the last received byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, held until bus_wait is low |
| bus_addr | input | 1 | 0 = configuration, 1 = data/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| bus_wait | output | 1 | Write stalled while a byte is in progress |
| irq | output | 1 | One-clock end-of-byte pulse |
| ext_sck | output | 1 | External serial clock |
| ext_mosi | output | 1 | External serial data out |
| ext_cs | output | 1 | External chip select |
| ext_miso | input | 1 | External serial data in |
| int_sck | output | 1 | Internal port serial clock |
| int_mosi | output | 1 | Internal port serial data out |
| int_cs | output | 1 | Internal port chip select |
| int_miso | input | 1 | Internal port serial data in |

## Verification
Two things can meet in the same cycle: a bus write can arrive in the cycle in which the byte engine ends, and the end of a byte coincides with the chip-select release decision. The bench provokes the first by issuing a second data write, or a config write, right after a byte starts. It then holds the strobe until bus_wait drops, expects the stall to have been seen, and expects the held write to land only after busy falls. For the second, the bench mixes stream and non-stream settings across random configurations. After each byte it judges the chip-select level on the routed pin set against the stream bit. An explicit release write then ends a streamed run.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int CFG_W   = 16;
   localparam int PRESC_W = 8;

   typedef struct packed {
      logic               route_int;
      logic               irq_en;
      logic               enable;
      logic               stream;
      logic               same_edge;
      logic               sck_inv;
      logic               cs_high;
      logic               lsb_first;
      logic [PRESC_W-1:0] presc;
   } spim_cfg_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_HOLD  = 2'd3
   } spim_state_e;

   // terminal count of the half-period counter: a zero prescaler acts as one
   function automatic logic [PRESC_W-1:0] half_limit(input logic [PRESC_W-1:0] p);
      return (p == '0) ? PRESC_W'(1) : p;
   endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
   import spim_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] limit,
   output logic               tick
);

   logic [PRESC_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              lsb_first,
   input  logic              advance,
   input  logic              sample,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data
);

   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;

   assign mosi    = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
   assign rx_data = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_q <= '0;
      else if (load)
         tx_q <= load_data;
      else if (advance)
         tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_q <= '0;
      else if (sample)
         rx_q <= lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
   end

endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int PRESC_RST = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [CFG_W-1:0] bus_wdata,
   input  logic             busy,
   output spim_cfg_t        cfg,
   output logic             cfg_wr,
   output logic             data_wr,
   output logic             cs_release,
   output logic             bus_wait
);

   localparam spim_cfg_t CFG_RST = spim_cfg_t'({8'h00, PRESC_W'(PRESC_RST)});

   spim_cfg_t wcfg;
   spim_cfg_t cfg_q;

   assign wcfg       = spim_cfg_t'(bus_wdata);
   assign bus_wait   = bus_wr && busy;
   assign cfg_wr     = bus_wr && !busy && !bus_addr;
   assign data_wr    = bus_wr && !busy && bus_addr;
   assign cs_release = cfg_wr && (!wcfg.stream || !wcfg.enable);
   assign cfg        = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RST;
      else if (cfg_wr)
         cfg_q <= wcfg;
   end

endmodule

// File: rtl/spim_portdrv.sv
module spim_portdrv (
   input  logic sel,
   input  logic sck_in,
   input  logic mosi_in,
   input  logic cs_in,
   input  logic sck_idle,
   input  logic cs_idle,
   output logic sck,
   output logic mosi,
   output logic cs
);

   assign sck  = sel ? sck_in  : sck_idle;
   assign mosi = sel ? mosi_in : 1'b0;
   assign cs   = sel ? cs_in   : cs_idle;

endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PRESC_RST = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [CFG_W-1:0] bus_wdata,
   output logic [CFG_W-1:0] bus_rdata,
   output logic             bus_wait,
   output logic             irq,
   output logic             ext_sck,
   output logic             ext_mosi,
   output logic             ext_cs,
   input  logic             ext_miso,
   output logic             int_sck,
   output logic             int_mosi,
   output logic             int_cs,
   input  logic             int_miso
);

   localparam int              EDGE_W    = $clog2(2 * DATA_W);
   localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(2 * DATA_W - 1);
   localparam int              PAD_W     = CFG_W - 1 - DATA_W;
   localparam int              NPORT     = 2;

   initial begin
      assert (DATA_W >= 2 && DATA_W <= CFG_W - 2);
      assert (PRESC_RST >= 0 && PRESC_RST < (1 << PRESC_W));
   end

   spim_cfg_t         cfg;
   logic              cfg_wr, data_wr, cs_release;
   logic              busy, tick;
   spim_state_e       state_q;
   logic [EDGE_W-1:0] edge_q;
   logic              sck_q, cs_q, irq_q;
   logic              leading, last_edge, sample, advance;
   logic              miso_sel, mosi_raw;
   logic              sck_pin, mosi_pin, cs_pin;
   logic [DATA_W-1:0] rx_data;
   logic [NPORT-1:0]  p_sck, p_mosi, p_cs;

   assign busy = (state_q != ST_IDLE);

   spim_regs #(.PRESC_RST(PRESC_RST)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .busy       (busy),
      .cfg        (cfg),
      .cfg_wr     (cfg_wr),
      .data_wr    (data_wr),
      .cs_release (cs_release),
      .bus_wait   (bus_wait)
   );

   spim_clkgen u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .limit (half_limit(cfg.presc)),
      .tick  (tick)
   );

   assign leading   = !edge_q[0];
   assign last_edge = (edge_q == EDGE_LAST);
   assign sample    = (state_q == ST_SHIFT) && tick && (leading ^ cfg.same_edge);
   assign advance   = (state_q == ST_SHIFT) && tick && !leading && !last_edge;

   spim_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (data_wr && cfg.enable),
      .load_data (bus_wdata[DATA_W-1:0]),
      .lsb_first (cfg.lsb_first),
      .advance   (advance),
      .sample    (sample),
      .miso      (miso_sel),
      .mosi      (mosi_raw),
      .rx_data   (rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         edge_q  <= '0;
         sck_q   <= 1'b0;
         cs_q    <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (data_wr && cfg.enable) begin
                  state_q <= ST_SETUP;
                  cs_q    <= 1'b1;
                  edge_q  <= '0;
               end else if (cs_release) begin
                  cs_q <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (tick)
                  state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tick) begin
                  sck_q  <= ~sck_q;
                  edge_q <= edge_q + 1'b1;
                  if (last_edge)
                     state_q <= ST_HOLD;
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  state_q <= ST_IDLE;
                  irq_q   <= cfg.irq_en;
                  if (!cfg.stream)
                     cs_q <= 1'b0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign irq       = irq_q;
   assign sck_pin   = sck_q ^ cfg.sck_inv;
   assign cs_pin    = cs_q ^ ~cfg.cs_high;
   assign mosi_pin  = cs_q & mosi_raw;
   assign miso_sel  = cfg.route_int ? int_miso : ext_miso;

   // port 0 is the external pin set, port 1 the internal slave port
   for (genvar g = 0; g < NPORT; g++) begin : g_port
      spim_portdrv u_drv (
         .sel      (cfg.route_int == (g == 1)),
         .sck_in   (sck_pin),
         .mosi_in  (mosi_pin),
         .cs_in    (cs_pin),
         .sck_idle (cfg.sck_inv),
         .cs_idle  (~cfg.cs_high),
         .sck      (p_sck[g]),
         .mosi     (p_mosi[g]),
         .cs       (p_cs[g])
      );
   end

   assign ext_sck  = p_sck[0];
   assign ext_mosi = p_mosi[0];
   assign ext_cs   = p_cs[0];
   assign int_sck  = p_sck[1];
   assign int_mosi = p_mosi[1];
   assign int_cs   = p_cs[1];

   assign bus_rdata = bus_addr ? {busy, {PAD_W{1'b0}}, rx_data} : CFG_W'(cfg);

endmodule

// File: rtl/spim_checker.sv
module spim_checker
   import spim_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      busy,
   input logic      cs_act,
   input logic      sck_int,
   input logic      irq,
   input spim_cfg_t cfg,
   input logic      ext_sck,
   input logic      ext_cs
);

   // R11
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R11
   irq_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!busy && $past(busy)));

   // R13
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg));

   // R8
   stream_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && cfg.stream) |-> cs_act);

   // R9
   byte_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !cfg.stream) |-> !cs_act);

   // R9
   cs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cs_act);

   // R2
   sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck_int);

   // R12
   ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.route_int |-> (ext_sck == cfg.sck_inv && ext_cs == !cfg.cs_high));

endmodule

bind spim_top spim_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .cs_act  (cs_q),
   .sck_int (sck_q),
   .irq     (irq),
   .cfg     (cfg),
   .ext_sck (ext_sck),
   .ext_cs  (ext_cs)
);

// File: tb/test_spim_top.sv
`timescale 1ns/1ps
module test_spim_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_wait, irq;
   logic        ext_sck, ext_mosi, ext_cs, int_sck, int_mosi, int_cs;
   logic        ext_miso = 1'b0;
   logic        int_miso;

   assign int_miso = int_mosi;   // internal port looped back

   always #2.5 clk = ~clk;

   spim_top i_spim_top (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .irq(irq),
      .ext_sck(ext_sck), .ext_mosi(ext_mosi), .ext_cs(ext_cs), .ext_miso(ext_miso),
      .int_sck(int_sck), .int_mosi(int_mosi), .int_cs(int_cs), .int_miso(int_miso)
   );

   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 0;
   logic [15:0] cfg_cur = 16'h0002;

   // slave model and monitor state
   bit          armed = 0;
   logic        prev_norm;
   logic [7:0]  sl_tx, sl_rx;
   int          sl_idx, n_edges, last_edge, irq_cnt, ext_bad, cyc;
   bit          have_last;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int half_of(input logic [7:0] p);
      return ((p == 0) ? 1 : int'(p)) + 1;
   endfunction

   function automatic int bpos(input int i, input logic lsb);
      return lsb ? i : 7 - i;
   endfunction

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      report();
   end

   // external slave model: mode 0 drives on trailing, mode 1 drives on leading
   always @(negedge clk) begin
      logic norm, csa;
      cyc++;
      if (armed) begin
         if (irq) irq_cnt++;
         if (cfg_cur[15]) begin
            if (ext_sck !== cfg_cur[10] || ext_cs !== !cfg_cur[9]) ext_bad++;
         end else begin
            norm = ext_sck ^ cfg_cur[10];
            csa  = (ext_cs == cfg_cur[9]);
            if (norm !== prev_norm) begin
               n_edges++;
               check(csa, "R9 cs active at edge", {31'd0, ext_cs}, {31'd0, cfg_cur[9]});
               if (have_last)
                  check(cyc - last_edge == half_of(cfg_cur[7:0]), "R3 half period",
                        cyc - last_edge, half_of(cfg_cur[7:0]));
               last_edge = cyc;
               have_last = 1;
               if (norm) begin
                  if (sl_idx < 8) begin
                     sl_rx[bpos(sl_idx, cfg_cur[8])] = ext_mosi;
                     if (cfg_cur[11]) ext_miso = sl_tx[bpos(sl_idx, cfg_cur[8])];
                  end
                  sl_idx++;
               end else if (!cfg_cur[11] && sl_idx < 8) begin
                  ext_miso = sl_tx[bpos(sl_idx, cfg_cur[8])];
               end
            end
            prev_norm = norm;
         end
      end
   end

   task automatic bus_write(input logic a, input logic [15:0] d, output bit waited);
      waited = 0;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #0.2;
      while (bus_wait) begin
         waited = 1;
         @(negedge clk); #0.2;
      end
      @(negedge clk);
      bus_wr = 1'b0;
      if (!a) cfg_cur = d;
   endtask

   task automatic read(input logic a, output logic [15:0] v);
      bus_addr = a;
      #0.2;
      v = bus_rdata;
   endtask

   task automatic write_cfg(input logic [15:0] d);
      bit w;
      bus_write(1'b0, d, w);
   endtask

   // one byte; returns cycles until busy reads 0
   task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, output int k, output logic [7:0] rx);
      logic [15:0] v;
      bit w;
      #0.1;
      sl_tx = sl; sl_rx = '0; sl_idx = 0; n_edges = 0; have_last = 0;
      irq_cnt = 0; ext_bad = 0;
      prev_norm = ext_sck ^ cfg_cur[10];
      if (!cfg_cur[11]) ext_miso = sl[bpos(0, cfg_cur[8])];
      armed = 1;
      bus_write(1'b1, {8'h00, tx}, w);
      k = 1;
      read(1'b1, v);
      while (v[15] && k < 20000) begin
         @(negedge clk);
         k++;
         read(1'b1, v);
      end
      rx = v[7:0];
      @(negedge clk);
      armed = 0;
   endtask

   initial begin
      logic [15:0] v;
      logic [7:0]  rx, tx, sl;
      int          k, h;
      bit          w;
      logic        exp_cs;
      void'($urandom(32'h5eed_1234));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read(1'b0, v);
      check(v == 16'h0002, "R1 cfg reset", v, 16'h0002);
      read(1'b1, v);
      check(v[15] == 1'b0, "R1 idle after reset", v, 0);
      check(ext_cs && int_cs && !ext_sck && !int_sck && !irq, "R1 pins at reset",
            {ext_cs, int_cs, ext_sck, int_sck, irq}, 5'b11000);

      // R10 disabled: write ignored
      write_cfg(16'h0002);
      xfer(8'h5A, 8'hC3, k, rx);
      check(k == 1, "R10 no busy when disabled", k, 1);
      check(rx == 8'h00, "R10 rx untouched", rx, 0);
      check(n_edges == 0 && ext_cs == 1'b1, "R10 no pin activity", n_edges, 0);

      // R2 R4 R7 R14 directed: MSB first, mode 0, ext, irq on, presc 0
      write_cfg(16'h6000);
      xfer(8'hA5, 8'h3C, k, rx);
      check(k == 18 * 2 + 1, "R2 byte length presc 0 (R3)", k, 37);
      check(n_edges == 16, "R2 sixteen edges", n_edges, 16);
      check(sl_rx == 8'hA5, "R4 mosi MSB first", sl_rx, 8'hA5);
      check(rx == 8'h3C, "R14 rx readback", rx, 8'h3C);
      check(irq_cnt == 1, "R11 one irq pulse", irq_cnt, 1);
      check(ext_cs == 1'b1, "R9 cs released", ext_cs, 1);

      // R4 R5 R6 R7: LSB first, cs high, sck inverted, same edge, irq off
      write_cfg(16'h2F03);
      xfer(8'h1E, 8'hB4, k, rx);
      check(sl_rx == 8'h1E, "R4 mosi LSB first", sl_rx, 8'h1E);
      check(rx == 8'hB4, "R7 trailing-edge sample", rx, 8'hB4);
      check(irq_cnt == 0, "R11 no irq when disabled", irq_cnt, 0);
      check(ext_cs == 1'b0 && ext_sck == 1'b1, "R5 R6 idle levels", {ext_cs, ext_sck}, 2'b01);

      // R8 stream: cs stays, release on config write
      write_cfg(16'h3001);
      xfer(8'h81, 8'h7E, k, rx);
      check(ext_cs == 1'b0, "R8 cs held after byte", ext_cs, 0);
      xfer(8'h42, 8'h99, k, rx);
      check(ext_cs == 1'b0 && rx == 8'h99, "R8 second streamed byte", {ext_cs, rx}, 9'h099);
      write_cfg(16'h2001);
      #0.2;
      check(ext_cs == 1'b1, "R8 release by config write", ext_cs, 1);

      // R13 data write while busy, internal loopback
      write_cfg(16'hA003);
      bus_write(1'b1, 16'h00C5, w);
      bus_write(1'b1, 16'h0037, w);
      check(w == 1'b1, "R13 data write stalled", w, 1);
      read(1'b1, v);
      while (v[15]) begin @(negedge clk); read(1'b1, v); end
      check(v[7:0] == 8'h37, "R13 held write ran", v[7:0], 8'h37);
      check(ext_cs == 1'b1 && ext_sck == 1'b0, "R12 ext idle", {ext_cs, ext_sck}, 2'b10);

      // R13 config write while busy
      bus_write(1'b1, 16'h0011, w);
      bus_write(1'b0, 16'h2004, w);
      check(w == 1'b1, "R13 config write stalled", w, 1);
      read(1'b0, v);
      check(v == 16'h2004, "R13 held config applied", v, 16'h2004);

      // random mix
      for (int i = 0; i < 40; i++) begin
         logic [15:0] c;
         c = $urandom;
         c[7:0] = 8'($urandom % 5);
         c[13]  = 1'b1;
         if (i % 7 == 0) c[7:0] = 8'h00;
         write_cfg(c);
         tx = 8'($urandom);
         sl = 8'($urandom);
         h  = half_of(c[7:0]);
         xfer(tx, sl, k, rx);
         check(k == 18 * h + 1, "R2 R3 byte length", k, 18 * h + 1);
         check(irq_cnt == int'(c[14]), "R11 irq count", irq_cnt, c[14]);
         exp_cs = c[12] ? c[9] : !c[9];
         if (c[15]) begin
            check(rx == tx, "R12 internal loopback", rx, tx);
            check(ext_bad == 0, "R12 ext held idle", ext_bad, 0);
            check(int_cs == exp_cs, "R8 R9 cs after byte", int_cs, exp_cs);
         end else begin
            check(rx == sl, "R7 R4 rx from slave", rx, sl);
            check(sl_rx == tx, "R4 slave saw tx", sl_rx, tx);
            check(n_edges == 16, "R2 edge count", n_edges, 16);
            check(ext_cs == exp_cs, "R8 R9 cs after byte", ext_cs, exp_cs);
         end
         write_cfg(c & 16'hEFFF);
      end

      report();
   end

endmodule